// File: doc/BRIEF.md
# Set-Associative Cache Hit/Miss Model

This block tracks only the tag state of a parameterized set-associative cache that allocates on every reference. It stores no data. Each request carries a byte address and an access length. The block classifies the request as a hit or a miss and keeps each set's tags in most-recently-used to least-recently-used order. It is meant for performance models and on-chip reference tracing, where a stream of references needs a cheap hit/miss verdict.

A request is accepted through a valid/ready handshake. The address splits into a line offset, a set index taken by plain bit selection, and a tag made of the remaining upper bits. The block finds the set of the first byte and the set of the last byte. If both are the same set, one lookup is done. If the last byte falls in the next set, wrapping from the top set back to set zero, both sets are looked up and updated in turn, and the whole reference still counts as one access with at most one miss. Any other layout is rejected with an error and leaves all state as it was. Each lookup takes one cycle, and the result is a one-cycle response pulse. Two running counters, one for accesses and one for misses, are visible at all times.

Top module: `cache_hitmodel`

## Requirements
- R1: During and just after reset, reqReady is 1, rspValid is 0 and both counters are 0. Every tag entry is cleared to 0 and there is no valid bit, so a first reference whose tag is 0 hits.
- R2: With the defaults (128-byte cache, 8-byte lines, 2 ways, so 8 sets), the set index is address bits [5:3] and the tag is the address shifted right by 6.
- R3: A hit in MRU position 0 leaves the set unchanged. A hit in position i>0 moves that tag to position 0 and shifts positions 0..i-1 down one place.
- R4: A miss shifts every entry of the set down one place, drops the LRU tag and installs the new tag at position 0.
- R5: A reference that stays within one set or is rejected responds on the second rising edge after the accepting edge. A reference that spans two sets responds on the third.
- R6: When the last byte (address + size - 1) falls in set (first set + 1) mod sets, the first set is processed and then the second. The response is a hit only if both lookups hit, and a miss otherwise.
- R7: In a spanning reference, the tag computed from the start address is compared against and installed in both sets.
- R8: A size of 0, a size above 16, or a last byte outside the same set and the next set gives rspErr=1 with rspHit=rspMiss=0. No tag and no counter changes.
- R9: accessCount advances by exactly 1 for each non-rejected reference, including spanning ones. missCount advances by 1 for each reference reported as a miss.
- R10: reqReady is 0 from the cycle after acceptance until the response cycle. When rspValid is 1, exactly one of rspHit, rspMiss and rspErr is 1. When rspValid is 0, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | ADDR_W | Byte address of the first byte |
| reqSize | input | SIZE_W | Access length in bytes (1 to MAX_SIZE) |
| rspValid | output | 1 | One-cycle response pulse |
| rspHit | output | 1 | Reference hit |
| rspMiss | output | 1 | Reference missed |
| rspErr | output | 1 | Reference rejected |
| accessCount | output | CNT_W | Accepted, non-rejected references |
| missCount | output | CNT_W | References reported as misses |

## Verification
The assertions check on every cycle that the response flags are mutually exclusive. They also check that the handshake drops ready after an acceptance, that no response comes in the cycle right after acceptance, and that the counters move only on a response, by one, and not at all on a rejection. Only the directed scenarios can show the recency ordering and the eviction choice. The same holds for the rule that a spanning reference installs the start-address tag in both sets, for wraparound from the top set, and for the fact that a rejected reference leaves the tag order untouched. These effects become visible only through the verdicts of later references.

// File: rtl/cachemdl_pkg.sv
package cachemdl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } ctrlState_e;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic capture;    // latch the incoming request
    logic lookup;     // look up and update one set
    logic useSecond;  // the lookup targets the second set
    logic finish;     // emit a hit/miss response
    logic reject;     // emit an error response
  } ctrlStrobe_t;

endpackage

// File: rtl/cache_setupd.sv
// Recency-ordered update of one set: position 0 holds the MRU tag.
module cache_setupd #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 26
) (
  input  logic [WAYS-1:0][TAG_W-1:0] rowIn,
  input  logic [TAG_W-1:0]           tagIn,
  output logic [WAYS-1:0][TAG_W-1:0] rowOut,
  output logic                       hit
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]  match;
  logic [WAY_W-1:0] stopPos;

  for (genvar g = 0; g < WAYS; g++) begin : g_match
    assign match[g] = (rowIn[g] == tagIn);
  end

  // Lowest matching position wins; on a miss the whole set shifts.
  always_comb begin
    hit     = |match;
    stopPos = WAY_W'(WAYS - 1);
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) stopPos = WAY_W'(i);
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_shift
    if (g == 0) begin : g_front
      assign rowOut[0] = tagIn;
    end else begin : g_rest
      assign rowOut[g] = (WAY_W'(g) <= stopPos) ? rowIn[g-1] : rowIn[g];
    end
  end

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cachemdl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        straddleQ,
  input  logic        errQ,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);
  ctrlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    reqReady  = (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (errQ) begin
          strobe.reject = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          strobe.lookup = 1'b1;
          if (straddleQ) begin
            stateNext = ST_SECOND;
          end else begin
            strobe.finish = 1'b1;
            stateNext     = ST_IDLE;
          end
        end
      end
      ST_SECOND: begin
        strobe.lookup    = 1'b1;
        strobe.useSecond = 1'b1;
        strobe.finish    = 1'b1;
        stateNext        = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/cache_datapath.sv
module cache_datapath
  import cachemdl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 128,
  parameter int WAYS        = 2,
  parameter int LINE_BYTES  = 8,
  parameter int MAX_SIZE    = 16,
  parameter int SIZE_W      = 5,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  output logic              straddleQ,
  output logic              errQ,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspErr,
  output logic [CNT_W-1:0]  accessCount,
  output logic [CNT_W-1:0]  missCount
);
  localparam int SETS      = CACHE_BYTES / LINE_BYTES / WAYS;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int SET_BITS  = $clog2(SETS);
  localparam int SET_W     = (SETS > 1) ? SET_BITS : 1;
  localparam int TAG_SHIFT = OFF_W + SET_BITS;
  localparam int TAG_W     = ADDR_W - TAG_SHIFT;

  // Decode of the incoming request.
  logic [ADDR_W-1:0] lastAddr, firstLine, lastLine;
  logic [SET_W-1:0]  firstSet, lastSet, nextSet;
  logic [TAG_W-1:0]  inTag;
  logic              sizeBad, spanOne, spanNext;

  assign lastAddr  = reqAddr + ADDR_W'(reqSize) - ADDR_W'(1);
  assign firstLine = reqAddr >> OFF_W;
  assign lastLine  = lastAddr >> OFF_W;
  assign firstSet  = SET_W'(firstLine & ADDR_W'(SETS - 1));
  assign lastSet   = SET_W'(lastLine & ADDR_W'(SETS - 1));
  assign nextSet   = (SETS == 1) ? '0 : SET_W'(firstSet + 1'b1);
  assign inTag     = TAG_W'(reqAddr >> TAG_SHIFT);
  assign sizeBad   = (reqSize == '0) || (int'(reqSize) > MAX_SIZE);
  assign spanOne   = (lastSet == firstSet);
  assign spanNext  = !spanOne && (lastSet == nextSet);

  // Latched request.
  logic [SET_W-1:0] set1Q, set2Q;
  logic [TAG_W-1:0] tagQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      set1Q     <= '0;
      set2Q     <= '0;
      tagQ      <= '0;
      straddleQ <= 1'b0;
      errQ      <= 1'b0;
    end else if (strobe.capture) begin
      set1Q     <= firstSet;
      set2Q     <= lastSet;
      tagQ      <= inTag;
      straddleQ <= spanNext;
      errQ      <= sizeBad || !(spanOne || spanNext);
    end
  end

  // Tag store and lookup.
  logic [WAYS-1:0][TAG_W-1:0] tagMem [SETS];
  logic [WAYS-1:0][TAG_W-1:0] rowCur, rowNew;
  logic [SET_W-1:0]           curSet;
  logic                       curHit, missAcc, finalMiss;

  assign curSet = strobe.useSecond ? set2Q : set1Q;
  assign rowCur = tagMem[curSet];

  cache_setupd #(.WAYS(WAYS), .TAG_W(TAG_W)) u_setupd (
    .rowIn  (rowCur),
    .tagIn  (tagQ),
    .rowOut (rowNew),
    .hit    (curHit)
  );

  assign finalMiss = !curHit || (strobe.useSecond && missAcc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) tagMem[s] <= '0;
    end else if (strobe.lookup) begin
      tagMem[curSet] <= rowNew;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              missAcc <= 1'b0;
    else if (strobe.lookup) missAcc <= finalMiss;
  end

  // Response pulse and running counters.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspMiss     <= 1'b0;
      rspErr      <= 1'b0;
      accessCount <= '0;
      missCount   <= '0;
    end else begin
      rspValid <= strobe.finish || strobe.reject;
      rspHit   <= strobe.finish && !finalMiss;
      rspMiss  <= strobe.finish && finalMiss;
      rspErr   <= strobe.reject;
      if (strobe.finish) begin
        accessCount <= accessCount + CNT_W'(1);
        if (finalMiss) missCount <= missCount + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/cache_hitmodel.sv
module cache_hitmodel
  import cachemdl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 128,
  parameter int WAYS        = 2,
  parameter int LINE_BYTES  = 8,
  parameter int MAX_SIZE    = 16,
  parameter int SIZE_W      = 5,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspErr,
  output logic [CNT_W-1:0]  accessCount,
  output logic [CNT_W-1:0]  missCount
);
  ctrlStrobe_t strobe;
  logic        straddleQ, errQ;

  cache_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .straddleQ (straddleQ),
    .errQ      (errQ),
    .reqReady  (reqReady),
    .strobe    (strobe)
  );

  cache_datapath #(
    .ADDR_W      (ADDR_W),
    .CACHE_BYTES (CACHE_BYTES),
    .WAYS        (WAYS),
    .LINE_BYTES  (LINE_BYTES),
    .MAX_SIZE    (MAX_SIZE),
    .SIZE_W      (SIZE_W),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqSize     (reqSize),
    .straddleQ   (straddleQ),
    .errQ        (errQ),
    .rspValid    (rspValid),
    .rspHit      (rspHit),
    .rspMiss     (rspMiss),
    .rspErr      (rspErr),
    .accessCount (accessCount),
    .missCount   (missCount)
  );

endmodule

// File: rtl/cache_hitmodel_chk.sv
module cache_hitmodel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rspValid,
  input logic             rspHit,
  input logic             rspMiss,
  input logic             rspErr,
  input logic [CNT_W-1:0] accessCount,
  input logic [CNT_W-1:0] missCount
);
  assert_flags_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspHit, rspMiss, rspErr}) == 1);

  assert_flags_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspHit || rspMiss || rspErr));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_no_early_rsp_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !rspValid);

  assert_access_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspErr) |-> accessCount == $past(accessCount) + CNT_W'(1));

  assert_miss_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> missCount == $past(missCount) + CNT_W'(1));

  assert_counts_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> ($stable(accessCount) && $stable(missCount)));

  assert_err_no_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (accessCount == $past(accessCount) && missCount == $past(missCount)));

endmodule

bind cache_hitmodel cache_hitmodel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .rspValid    (rspValid),
  .rspHit      (rspHit),
  .rspMiss     (rspMiss),
  .rspErr      (rspErr),
  .accessCount (accessCount),
  .missCount   (missCount)
);

// File: tb/test_cache_hitmodel.sv
`timescale 1ns/1ps
module test_cache_hitmodel;
  localparam int KH = 0;  // expect hit
  localparam int KM = 1;  // expect miss
  localparam int KE = 2;  // expect error

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [4:0]  reqSize = '0;
  logic        rspValid, rspHit, rspMiss, rspErr;
  logic [31:0] accessCount, missCount;

  int nChecks = 0;
  int nFails  = 0;
  int expAcc  = 0;
  int expMiss = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  cache_hitmodel i_cache_hitmodel (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .rspValid(rspValid),
    .rspHit(rspHit), .rspMiss(rspMiss), .rspErr(rspErr),
    .accessCount(accessCount), .missCount(missCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One reference: drive, wait for the response, check verdict, latency, counters.
  task automatic doRef(input logic [31:0] addr, input int size, input int kind,
                       input int expLat, input string req);
    int lat = 0;
    @(negedge clk);
    check(reqReady == 1'b1, {req, " ready before request"}, int'(reqReady), 1);
    reqAddr  = addr;
    reqSize  = 5'(size);
    reqValid = 1'b1;
    @(posedge clk);
    while (1) begin
      @(negedge clk);
      reqValid = 1'b0;
      lat++;
      if (lat == 1) check(reqReady == 1'b0, "R10 busy after accept", int'(reqReady), 0);
      if (rspValid || lat > 10) break;
    end
    if (kind == KH) expAcc++;
    if (kind == KM) begin expAcc++; expMiss++; end
    check(lat == expLat, {req, " R5 latency"}, lat, expLat);
    check(rspHit == (kind == KH), {req, " hit flag"}, int'(rspHit), int'(kind == KH));
    check(rspMiss == (kind == KM), {req, " miss flag"}, int'(rspMiss), int'(kind == KM));
    check(rspErr == (kind == KE), {req, " R8 err flag"}, int'(rspErr), int'(kind == KE));
    check(accessCount == 32'(expAcc), {req, " R9 accessCount"}, int'(accessCount), expAcc);
    check(missCount == 32'(expMiss), {req, " R9 missCount"}, int'(missCount), expMiss);
    @(negedge clk);
    check(rspValid == 1'b0, {req, " R10 single pulse"}, int'(rspValid), 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(reqReady == 1'b1, "R1 ready in reset", int'(reqReady), 1);
    check(rspValid == 1'b0, "R1 no response in reset", int'(rspValid), 0);
    check(accessCount == 0 && missCount == 0, "R1 counters cleared",
          int'(accessCount + missCount), 0);
  endtask

  // Set 7 wraps to set 0. Tag 0 hits in cleared sets; tag 3 is installed in both.
  task automatic testWrap();
    doRef(32'h3C, 8, KH, 3, "R1 R6 wrap tag0 both hit");
    doRef(32'hFC, 8, KM, 3, "R6 wrap tag3 both miss");
    doRef(32'hC0, 1, KH, 2, "R7 tag3 in second set");
    doRef(32'hF8, 1, KH, 2, "R7 tag3 in first set");
  endtask

  // Recency order in set 2 (R2: set bits [5:3], tag addr>>6).
  task automatic testLru();
    doRef(32'h50,  4, KM, 2, "R2 R4 tag1 miss");
    doRef(32'h10,  4, KH, 2, "R3 tag0 hit at pos1");
    doRef(32'h10,  4, KH, 2, "R3 tag0 hit at pos0");
    doRef(32'h110, 4, KM, 2, "R4 tag4 evicts tag1");
    doRef(32'h50,  4, KM, 2, "R4 tag1 was evicted");
    doRef(32'h110, 4, KH, 2, "R3 tag4 hit at pos1");
    doRef(32'h10,  4, KM, 2, "R4 tag0 was LRU");
    doRef(32'h110, 4, KH, 2, "R3 tag4 kept");
  endtask

  // Spanning references with one hit and one miss.
  task automatic testMixed();
    doRef(32'h1E8, 4, KM, 2, "R4 tag7 set5");
    doRef(32'h1EC, 8, KM, 3, "R6 first hit second miss");
    doRef(32'h1F0, 1, KH, 2, "R7 tag7 installed set6");
    doRef(32'h160, 1, KM, 2, "R4 tag5 set4");
    doRef(32'h15C, 8, KM, 3, "R6 first miss second hit");
    doRef(32'h158, 1, KH, 2, "R6 tag5 installed set3");
  endtask

  // Rejections change nothing: set 0 holds [3,0] before this.
  task automatic testError();
    doRef(32'h4,  16, KE, 2, "R8 spans three sets");
    doRef(32'h0,   0, KE, 2, "R8 zero size");
    doRef(32'h0,  17, KE, 2, "R8 oversize");
    doRef(32'h140, 1, KM, 2, "R8 tag5 evicts LRU tag0");
    doRef(32'hC0,  1, KH, 2, "R8 order untouched tag3 kept");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWrap();
    testLru();
    testMixed();
    testError();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule